// File: doc/BRIEF.md
# I2C Configuration Register Bank with Staged Commit

This block is an I2C target that holds the control map of a clock synthesizer. A host writes a register index after the write address byte, then one or more data bytes. It reads by sending the index, a repeated start and the read address. The index advances after every data byte in both directions, so a host can stream through consecutive registers. Two identification registers and one status register can only be read. The status register reflects two lock inputs.

The loop-setting registers (1h to 3h) and the phase-control register (5h) are double-buffered. Bus writes land in a shadow copy, which reads back at once. The working copy that drives the outputs changes only when the host writes a key value to the write-only commit register 8h. The high nibble 5h commits the loop group. The low nibble Ah commits the phase group. Both take effect as the acknowledge of that data byte closes. A one-cycle load strobe per group marks the update.

SCL and SDA are brought into the system clock domain before any edge is detected. The system clock must run at least eight times faster than SCL. The target pulls SDA low through an open-drain enable.

Top module: `i2c_cfg_bank`

## Requirements
- R1: The target acknowledges an address byte only when its upper seven bits equal 010011 followed by the level of `addrSel`, with bit 0 giving the direction (0 write, 1 read): 4Ch/4Dh with `addrSel` low, 4Eh/4Fh with it high. A byte to any other address is not acknowledged and changes no register.
- R2: The first byte after a write address is the register index. Each later data byte, written or read, goes to the current index, and the index then increments by one.
- R3: Data bits move most-significant bit first in both directions.
- R4: After reset the registers hold 0h=41h, 1h=00h, 2h=FFh, 3h=0Fh, 4h=00h, 5h=03h, 6h=00h, 7h=80h, and the working outputs show the same values.
- R5: A write to 1h, 2h, 3h or 5h is readable at once, but `loopWork`, `fbLoWork`, `fbHiWork` and `phaseWork` keep their value until the matching commit. Registers 0h, 4h, 6h and 7h drive their outputs directly.
- R6: A data byte written to 8h with high nibble 5h copies shadows 1h to 3h to the working outputs and pulses `loopLoad` once. A low nibble of Ah copies shadow 5h and pulses `phaseLoad` once. 5Ah does both. Any other nibble triggers nothing. The pulses come after the acknowledge of that byte ends and before any stop. Register 8h reads 00h.
- R7: Register 10h reads 17h and 11h reads 01h. Register 12h reads `phaseLock` in bit 0, `loopLock` in bit 1 and zeros above. Writes to these three are acknowledged and ignored.
- R8: Register 5h bits 7:2 read back as written until a byte with bits 7:2 all ones is written there. From then on, a read of those bits returns the fixed code 101101b, and bits 1:0 still read as written.
- R9: Writes to unmapped indices (9h to Fh, 13h and up) are acknowledged and ignored, and reads of them return 00h.
- R10: When the host answers a read byte with no-acknowledge, the target releases SDA and does not drive it again until the next start condition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x SCL |
| rstN | input | 1 | Active-low synchronous reset |
| sclIn | input | 1 | Bus clock line level |
| sdaIn | input | 1 | Bus data line level |
| sdaOe | output | 1 | Pull SDA low when 1 |
| addrSel | input | 1 | Selects the low bit of the target address |
| phaseLock | input | 1 | Phase aligner lock status |
| loopLock | input | 1 | Loop lock status |
| srcCfg | output | 8 | Register 0h, input control |
| loopWork | output | 8 | Working copy of register 1h |
| fbLoWork | output | 8 | Working copy of register 2h |
| fbHiWork | output | 8 | Working copy of register 3h (upper nibble 0) |
| phaseOfs | output | 8 | Register 4h, phase offset |
| phaseWork | output | 8 | Working copy of register 5h |
| outCfg | output | 8 | Register 6h, output enables |
| oscCfg | output | 8 | Register 7h, oscillator divider and input select |
| loopLoad | output | 1 | One-cycle pulse when the loop group commits |
| phaseLoad | output | 1 | One-cycle pulse when the phase group commits |

## Verification
The main function is tried with single writes and reads, sequential writes and reads, and addresses that match and do not match under both levels of `addrSel`. Single-bit patterns such as 01h separate MSB-first from LSB-first shifting. The commit register is driven with 5Fh, 3Ah, 33h and 5Ah, which separates the two groups, shows that the other nibble has no effect, and shows the combined key. The strobe counts are sampled before the stop, which ties each commit to its acknowledge and not to the end of the transaction. Sequential transfers that cross into the commit register and unmapped indices, and a no-acknowledged read followed by idle clocks, check increment, ignore and release behaviour.

// File: rtl/cfgbank_pkg.sv
package cfgbank_pkg;
  localparam int BYTE_BITS = 8;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_ADDR_ACK, ST_WRITE, ST_WRITE_ACK, ST_READ, ST_READ_ACK
  } busState_t;

  // strobes from the bus controller to the register datapath
  typedef struct packed {
    logic                 wrEn;
    logic [BYTE_BITS-1:0] wrIdx;
    logic [BYTE_BITS-1:0] wrData;
    logic                 loopLoad;
    logic                 phaseLoad;
  } bankStrobe_t;

  localparam logic [7:0] IDX_SRC    = 8'h00;
  localparam logic [7:0] IDX_LOOP   = 8'h01;
  localparam logic [7:0] IDX_FBLO   = 8'h02;
  localparam logic [7:0] IDX_FBHI   = 8'h03;
  localparam logic [7:0] IDX_PHOFS  = 8'h04;
  localparam logic [7:0] IDX_PHCTL  = 8'h05;
  localparam logic [7:0] IDX_OUTEN  = 8'h06;
  localparam logic [7:0] IDX_OSC    = 8'h07;
  localparam logic [7:0] IDX_COMMIT = 8'h08;
  localparam logic [7:0] IDX_ID     = 8'h10;
  localparam logic [7:0] IDX_REV    = 8'h11;
  localparam logic [7:0] IDX_STAT   = 8'h12;

  localparam logic [3:0] LOOP_KEY  = 4'h5;
  localparam logic [3:0] PHASE_KEY = 4'hA;
endpackage

// File: rtl/line_sync.sv
module line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  // bus lines idle high, so the chain resets high
  always_ff @(posedge clk) begin
    if (!rstN) chain <= '1;
    else       chain <= {chain[STAGES-2:0], din};
  end

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/i2c_tgt_ctl.sv
module i2c_tgt_ctl
  import cfgbank_pkg::*;
#(
  parameter logic [5:0] ADDR_HI = 6'b010011
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        scl,
  input  logic        sda,
  input  logic        addrSel,
  input  logic [7:0]  rdData,
  output logic        sdaDrive,
  output logic [7:0]  curIdx,
  output bankStrobe_t strobe
);
  localparam int CNT_W = $clog2(BYTE_BITS + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_BITS);

  logic sclQ, sdaQ;
  logic sclRise, sclFall, startEv, stopEv;
  busState_t state;
  logic [7:0] shiftQ;
  logic [CNT_W-1:0] bitCnt;
  logic isRead, firstByte, pendLoop, pendPhase, hostNack;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclQ <= 1'b1;
      sdaQ <= 1'b1;
    end else begin
      sclQ <= scl;
      sdaQ <= sda;
    end
  end

  assign sclRise = scl & ~sclQ;
  assign sclFall = ~scl & sclQ;
  assign startEv = scl & sclQ & sdaQ & ~sda;
  assign stopEv  = scl & sclQ & ~sdaQ & sda;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      shiftQ    <= '0;
      bitCnt    <= '0;
      isRead    <= 1'b0;
      firstByte <= 1'b0;
      pendLoop  <= 1'b0;
      pendPhase <= 1'b0;
      hostNack  <= 1'b0;
      sdaDrive  <= 1'b0;
      curIdx    <= '0;
      strobe    <= '0;
    end else begin
      strobe.wrEn      <= 1'b0;
      strobe.loopLoad  <= 1'b0;
      strobe.phaseLoad <= 1'b0;
      if (stopEv) begin
        state     <= ST_IDLE;
        sdaDrive  <= 1'b0;
        pendLoop  <= 1'b0;
        pendPhase <= 1'b0;
      end else if (startEv) begin
        state     <= ST_ADDR;
        bitCnt    <= '0;
        sdaDrive  <= 1'b0;
        pendLoop  <= 1'b0;
        pendPhase <= 1'b0;
      end else begin
        unique case (state)
          ST_ADDR: begin
            if (sclRise) begin
              shiftQ <= {shiftQ[6:0], sda};
              bitCnt <= bitCnt + 1'b1;
            end else if (sclFall && bitCnt == FULL) begin
              if (shiftQ[7:1] == {ADDR_HI, addrSel}) begin
                sdaDrive <= 1'b1;
                isRead   <= shiftQ[0];
                state    <= ST_ADDR_ACK;
              end else begin
                state <= ST_IDLE;
              end
            end
          end
          ST_ADDR_ACK: begin
            if (sclFall) begin
              bitCnt <= '0;
              if (isRead) begin
                state    <= ST_READ;
                shiftQ   <= rdData;
                sdaDrive <= ~rdData[7];
              end else begin
                state     <= ST_WRITE;
                sdaDrive  <= 1'b0;
                firstByte <= 1'b1;
              end
            end
          end
          ST_WRITE: begin
            if (sclRise) begin
              shiftQ <= {shiftQ[6:0], sda};
              bitCnt <= bitCnt + 1'b1;
            end else if (sclFall && bitCnt == FULL) begin
              sdaDrive <= 1'b1;
              state    <= ST_WRITE_ACK;
              if (firstByte) begin
                curIdx    <= shiftQ;
                firstByte <= 1'b0;
              end else begin
                strobe.wrEn   <= 1'b1;
                strobe.wrIdx  <= curIdx;
                strobe.wrData <= shiftQ;
                curIdx        <= curIdx + 1'b1;
                pendLoop      <= (curIdx == IDX_COMMIT) && (shiftQ[7:4] == LOOP_KEY);
                pendPhase     <= (curIdx == IDX_COMMIT) && (shiftQ[3:0] == PHASE_KEY);
              end
            end
          end
          ST_WRITE_ACK: begin
            if (sclFall) begin
              sdaDrive         <= 1'b0;
              bitCnt           <= '0;
              state            <= ST_WRITE;
              strobe.loopLoad  <= pendLoop;
              strobe.phaseLoad <= pendPhase;
              pendLoop         <= 1'b0;
              pendPhase        <= 1'b0;
            end
          end
          ST_READ: begin
            if (sclRise) begin
              bitCnt <= bitCnt + 1'b1;
            end else if (sclFall) begin
              if (bitCnt == FULL) begin
                sdaDrive <= 1'b0;
                state    <= ST_READ_ACK;
              end else begin
                shiftQ   <= {shiftQ[6:0], 1'b0};
                sdaDrive <= ~shiftQ[6];
              end
            end
          end
          ST_READ_ACK: begin
            if (sclRise) begin
              hostNack <= sda;
              curIdx   <= curIdx + 1'b1;
            end else if (sclFall) begin
              bitCnt <= '0;
              if (hostNack) begin
                state <= ST_IDLE;
              end else begin
                state    <= ST_READ;
                shiftQ   <= rdData;
                sdaDrive <= ~rdData[7];
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE) |-> !sdaDrive); // R10
  AST_LOAD_AT_ACK_END: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.loopLoad || strobe.phaseLoad) |-> ($past(state) == ST_WRITE_ACK)); // R6
  AST_LOOP_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loopLoad |=> !strobe.loopLoad); // R6
  AST_WRITE_AFTER_BYTE: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wrEn |-> ($past(state) == ST_WRITE)); // R2
endmodule

// File: rtl/cfg_bank_dp.sv
module cfg_bank_dp
  import cfgbank_pkg::*;
#(
  parameter logic [7:0] CHIP_ID  = 8'h17,
  parameter logic [7:0] CHIP_REV = 8'h01,
  parameter logic [5:0] REV_CODE = 6'b101101
) (
  input  logic        clk,
  input  logic        rstN,
  input  bankStrobe_t strobe,
  input  logic [7:0]  rdIdx,
  input  logic        phaseLock,
  input  logic        loopLock,
  output logic [7:0]  rdData,
  output logic [7:0]  srcCfg,
  output logic [7:0]  loopWork,
  output logic [7:0]  fbLoWork,
  output logic [7:0]  fbHiWork,
  output logic [7:0]  phaseOfs,
  output logic [7:0]  phaseWork,
  output logic [7:0]  outCfg,
  output logic [7:0]  oscCfg
);
  logic [7:0] srcQ, loopSh, fbLoSh, phSh, phOfsQ, outQ, oscQ;
  logic [3:0] fbHiSh, fbHiW;
  logic [7:0] loopW, fbLoW, phW;
  logic       revOpen;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      srcQ    <= 8'h41;
      loopSh  <= 8'h00;
      fbLoSh  <= 8'hFF;
      fbHiSh  <= 4'hF;
      phOfsQ  <= 8'h00;
      phSh    <= 8'h03;
      outQ    <= 8'h00;
      oscQ    <= 8'h80;
      loopW   <= 8'h00;
      fbLoW   <= 8'hFF;
      fbHiW   <= 4'hF;
      phW     <= 8'h03;
      revOpen <= 1'b0;
    end else begin
      if (strobe.wrEn) begin
        unique case (strobe.wrIdx)
          IDX_SRC:   srcQ   <= strobe.wrData;
          IDX_LOOP:  loopSh <= strobe.wrData;
          IDX_FBLO:  fbLoSh <= strobe.wrData;
          IDX_FBHI:  fbHiSh <= strobe.wrData[3:0];
          IDX_PHOFS: phOfsQ <= strobe.wrData;
          IDX_PHCTL: begin
            phSh <= strobe.wrData;
            if (strobe.wrData[7:2] == 6'h3F) revOpen <= 1'b1;
          end
          IDX_OUTEN: outQ <= strobe.wrData;
          IDX_OSC:   oscQ <= strobe.wrData;
          default: ;
        endcase
      end
      if (strobe.loopLoad) begin
        loopW <= loopSh;
        fbLoW <= fbLoSh;
        fbHiW <= fbHiSh;
      end
      if (strobe.phaseLoad) phW <= phSh;
    end
  end

  always_comb begin
    unique case (rdIdx)
      IDX_SRC:   rdData = srcQ;
      IDX_LOOP:  rdData = loopSh;
      IDX_FBLO:  rdData = fbLoSh;
      IDX_FBHI:  rdData = {4'h0, fbHiSh};
      IDX_PHOFS: rdData = phOfsQ;
      IDX_PHCTL: rdData = revOpen ? {REV_CODE, phSh[1:0]} : phSh;
      IDX_OUTEN: rdData = outQ;
      IDX_OSC:   rdData = oscQ;
      IDX_ID:    rdData = CHIP_ID;
      IDX_REV:   rdData = CHIP_REV;
      IDX_STAT:  rdData = {6'b0, loopLock, phaseLock};
      default:   rdData = 8'h00;
    endcase
  end

  assign srcCfg    = srcQ;
  assign loopWork  = loopW;
  assign fbLoWork  = fbLoW;
  assign fbHiWork  = {4'h0, fbHiW};
  assign phaseOfs  = phOfsQ;
  assign phaseWork = phW;
  assign outCfg    = outQ;
  assign oscCfg    = oscQ;

  AST_LOOP_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.loopLoad |=> ($stable(loopW) && $stable(fbLoW) && $stable(fbHiW))); // R5
  AST_PHASE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.phaseLoad |=> $stable(phW)); // R5
  AST_REV_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    revOpen |=> revOpen); // R8
endmodule

// File: rtl/i2c_cfg_bank.sv
module i2c_cfg_bank
  import cfgbank_pkg::*;
#(
  parameter int         SYNC_STAGES = 2,
  parameter logic [5:0] ADDR_HI     = 6'b010011,
  parameter logic [7:0] CHIP_ID     = 8'h17,
  parameter logic [7:0] CHIP_REV    = 8'h01,
  parameter logic [5:0] REV_CODE    = 6'b101101
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  output logic       sdaOe,
  input  logic       addrSel,
  input  logic       phaseLock,
  input  logic       loopLock,
  output logic [7:0] srcCfg,
  output logic [7:0] loopWork,
  output logic [7:0] fbLoWork,
  output logic [7:0] fbHiWork,
  output logic [7:0] phaseOfs,
  output logic [7:0] phaseWork,
  output logic [7:0] outCfg,
  output logic [7:0] oscCfg,
  output logic       loopLoad,
  output logic       phaseLoad
);
  localparam int LINES = 2;

  logic [LINES-1:0] rawLines, syncLines;
  bankStrobe_t strobe;
  logic [7:0]  curIdx, rdData;

  assign rawLines = {sdaIn, sclIn};

  for (genvar g = 0; g < LINES; g++) begin : gSync
    line_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk (clk), .rstN(rstN), .din(rawLines[g]), .dout(syncLines[g])
    );
  end

  i2c_tgt_ctl #(.ADDR_HI(ADDR_HI)) u_ctl (
    .clk(clk), .rstN(rstN), .scl(syncLines[0]), .sda(syncLines[1]),
    .addrSel(addrSel), .rdData(rdData), .sdaDrive(sdaOe),
    .curIdx(curIdx), .strobe(strobe)
  );

  cfg_bank_dp #(.CHIP_ID(CHIP_ID), .CHIP_REV(CHIP_REV), .REV_CODE(REV_CODE)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .rdIdx(curIdx),
    .phaseLock(phaseLock), .loopLock(loopLock), .rdData(rdData),
    .srcCfg(srcCfg), .loopWork(loopWork), .fbLoWork(fbLoWork), .fbHiWork(fbHiWork),
    .phaseOfs(phaseOfs), .phaseWork(phaseWork), .outCfg(outCfg), .oscCfg(oscCfg)
  );

  assign loopLoad  = strobe.loopLoad;
  assign phaseLoad = strobe.phaseLoad;
endmodule

// File: tb/i2c_cfg_bank_tb.sv
module i2c_cfg_bank_tb;
  localparam int QCYC = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclHost = 1'b1, sdaHost = 1'b1;
  logic addrSel = 1'b0, phaseLock = 1'b0, loopLock = 1'b0;
  logic sdaOe, sdaLine, loopLoad, phaseLoad;
  logic [7:0] srcCfg, loopWork, fbLoWork, fbHiWork, phaseOfs, phaseWork, outCfg, oscCfg;
  int checks = 0, errors = 0;
  int loopCnt = 0, phaseCnt = 0, oeHits = 0;
  logic oeWatch = 1'b0;
  logic ack;
  logic [7:0] rb;

  always #2 clk = ~clk;
  assign sdaLine = sdaHost & ~sdaOe;

  i2c_cfg_bank u_dut (
    .clk(clk), .rstN(rstN), .sclIn(sclHost), .sdaIn(sdaLine), .sdaOe(sdaOe),
    .addrSel(addrSel), .phaseLock(phaseLock), .loopLock(loopLock),
    .srcCfg(srcCfg), .loopWork(loopWork), .fbLoWork(fbLoWork), .fbHiWork(fbHiWork),
    .phaseOfs(phaseOfs), .phaseWork(phaseWork), .outCfg(outCfg), .oscCfg(oscCfg),
    .loopLoad(loopLoad), .phaseLoad(phaseLoad)
  );

  always @(posedge clk) begin
    if (loopLoad)  loopCnt  <= loopCnt + 1;
    if (phaseLoad) phaseCnt <= phaseCnt + 1;
    if (oeWatch && sdaOe) oeHits <= oeHits + 1;
  end

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic waitQ(input int n);
    repeat (n * QCYC) @(negedge clk);
  endtask

  task automatic i2cStart;
    sdaHost = 1'b1; waitQ(1);
    sclHost = 1'b1; waitQ(2);
    sdaHost = 1'b0; waitQ(2);
    sclHost = 1'b0; waitQ(1);
  endtask

  task automatic i2cStop;
    sdaHost = 1'b0; waitQ(1);
    sclHost = 1'b1; waitQ(2);
    sdaHost = 1'b1; waitQ(2);
  endtask

  task automatic sendByte(input logic [7:0] b, output logic gotAck);
    for (int i = 7; i >= 0; i--) begin
      waitQ(1); sdaHost = b[i];
      waitQ(1); sclHost = 1'b1;
      waitQ(2); sclHost = 1'b0;
    end
    waitQ(1); sdaHost = 1'b1;
    waitQ(1); sclHost = 1'b1;
    waitQ(1); gotAck = ~sdaLine;
    waitQ(1); sclHost = 1'b0;
  endtask

  task automatic recvByte(input logic nack, output logic [7:0] b);
    sdaHost = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      waitQ(2); sclHost = 1'b1;
      waitQ(1); b[i] = sdaLine;
      waitQ(1); sclHost = 1'b0;
    end
    waitQ(1); sdaHost = nack;
    waitQ(1); sclHost = 1'b1;
    waitQ(2); sclHost = 1'b0;
    waitQ(1); sdaHost = 1'b1;
  endtask

  function automatic logic [7:0] devAddr(input logic rd);
    return {6'b010011, addrSel, rd};
  endfunction

  task automatic wrReg(input logic [7:0] idx, input logic [7:0] d);
    logic a;
    i2cStart;
    sendByte(devAddr(1'b0), a);
    chk("R1 write address ack", {7'b0, a}, 8'h01);
    sendByte(idx, a);
    sendByte(d, a);
    i2cStop;
  endtask

  task automatic rdReg(input logic [7:0] idx, output logic [7:0] d);
    logic a;
    i2cStart;
    sendByte(devAddr(1'b0), a);
    sendByte(idx, a);
    i2cStart;
    sendByte(devAddr(1'b1), a);
    chk("R1 read address ack", {7'b0, a}, 8'h01);
    recvByte(1'b1, d);
    i2cStop;
  endtask

  task automatic testReset;
    chk("R4 reset srcCfg", srcCfg, 8'h41);
    chk("R4 reset loopWork", loopWork, 8'h00);
    chk("R4 reset fbLoWork", fbLoWork, 8'hFF);
    chk("R4 reset fbHiWork", fbHiWork, 8'h0F);
    chk("R4 reset phaseOfs", phaseOfs, 8'h00);
    chk("R4 reset phaseWork", phaseWork, 8'h03);
    chk("R4 reset outCfg", outCfg, 8'h00);
    chk("R4 reset oscCfg", oscCfg, 8'h80);
    chk("R4 reset sdaOe", {7'b0, sdaOe}, 8'h00);
    rdReg(8'h00, rb); chk("R4 read reg0", rb, 8'h41);
    rdReg(8'h03, rb); chk("R4 read reg3", rb, 8'h0F);
    rdReg(8'h05, rb); chk("R4 read reg5", rb, 8'h03);
  endtask

  task automatic testAddress;
    logic a;
    i2cStart; sendByte(8'h4E, a); i2cStop;
    chk("R1 4Eh ignored with addrSel low", {7'b0, a}, 8'h00);
    addrSel = 1'b1;
    i2cStart; sendByte(8'h4C, a); sendByte(8'h06, a); sendByte(8'h11, a); i2cStop;
    chk("R1 4Ch ignored with addrSel high", {7'b0, a}, 8'h00);
    chk("R1 unmatched write has no effect", outCfg, 8'h00);
    wrReg(8'h06, 8'h5C);
    chk("R1 write through 4Eh", outCfg, 8'h5C);
    rdReg(8'h06, rb); chk("R1 read through 4Fh", rb, 8'h5C);
    addrSel = 1'b0;
  endtask

  task automatic testMsbFirst;
    wrReg(8'h04, 8'h01);
    chk("R3 write MSB first", phaseOfs, 8'h01);
    rdReg(8'h04, rb); chk("R3 read MSB first 01h", rb, 8'h01);
    rdReg(8'h07, rb); chk("R3 read MSB first 80h", rb, 8'h80);
  endtask

  task automatic testShadow;
    logic a;
    int l0, p0;
    i2cStart; sendByte(devAddr(1'b0), a);
    sendByte(8'h01, a); sendByte(8'h24, a); sendByte(8'h3C, a); sendByte(8'h07, a);
    i2cStop;
    chk("R5 loopWork held", loopWork, 8'h00);
    chk("R5 fbLoWork held", fbLoWork, 8'hFF);
    chk("R5 fbHiWork held", fbHiWork, 8'h0F);
    i2cStart; sendByte(devAddr(1'b0), a); sendByte(8'h01, a);
    i2cStart; sendByte(devAddr(1'b1), a);
    recvByte(1'b0, rb); chk("R2 sequential read idx1", rb, 8'h24);
    recvByte(1'b0, rb); chk("R2 sequential read idx2", rb, 8'h3C);
    recvByte(1'b1, rb); chk("R2 sequential read idx3", rb, 8'h07);
    i2cStop;
    l0 = loopCnt; p0 = phaseCnt;
    i2cStart; sendByte(devAddr(1'b0), a); sendByte(8'h08, a); sendByte(8'h5F, a);
    waitQ(1);
    chk("R6 loop strobe before stop", 8'(loopCnt - l0), 8'h01);
    chk("R6 no phase strobe for 5Fh", 8'(phaseCnt - p0), 8'h00);
    i2cStop;
    chk("R6 loopWork committed", loopWork, 8'h24);
    chk("R6 fbLoWork committed", fbLoWork, 8'h3C);
    chk("R6 fbHiWork committed", fbHiWork, 8'h07);
    chk("R6 phaseWork untouched", phaseWork, 8'h03);
  endtask

  task automatic testPhaseCommit;
    int l0, p0;
    wrReg(8'h05, 8'h02);
    chk("R5 phaseWork held", phaseWork, 8'h03);
    rdReg(8'h05, rb); chk("R5 shadow readable", rb, 8'h02);
    l0 = loopCnt; p0 = phaseCnt;
    wrReg(8'h08, 8'h3A);
    chk("R6 phase strobe once", 8'(phaseCnt - p0), 8'h01);
    chk("R6 no loop strobe for 3Ah", 8'(loopCnt - l0), 8'h00);
    chk("R6 phaseWork committed", phaseWork, 8'h02);
    l0 = loopCnt; p0 = phaseCnt;
    wrReg(8'h08, 8'h33);
    chk("R6 33h commits nothing", 8'(loopCnt - l0 + phaseCnt - p0), 8'h00);
    wrReg(8'h01, 8'h11);
    wrReg(8'h05, 8'h01);
    l0 = loopCnt; p0 = phaseCnt;
    wrReg(8'h08, 8'h5A);
    chk("R6 5Ah loop strobe", 8'(loopCnt - l0), 8'h01);
    chk("R6 5Ah phase strobe", 8'(phaseCnt - p0), 8'h01);
    chk("R6 5Ah loopWork", loopWork, 8'h11);
    chk("R6 5Ah phaseWork", phaseWork, 8'h01);
    rdReg(8'h08, rb); chk("R6 commit register reads 00h", rb, 8'h00);
  endtask

  task automatic testIdent;
    rdReg(8'h10, rb); chk("R7 id register", rb, 8'h17);
    rdReg(8'h11, rb); chk("R7 revision register", rb, 8'h01);
    phaseLock = 1'b1; loopLock = 1'b0;
    rdReg(8'h12, rb); chk("R7 status phase lock", rb, 8'h01);
    phaseLock = 1'b0; loopLock = 1'b1;
    rdReg(8'h12, rb); chk("R7 status loop lock", rb, 8'h02);
    wrReg(8'h10, 8'h55);
    rdReg(8'h10, rb); chk("R7 id write ignored", rb, 8'h17);
  endtask

  task automatic testUnmapped;
    logic a;
    int l0, p0;
    l0 = loopCnt; p0 = phaseCnt;
    i2cStart; sendByte(devAddr(1'b0), a);
    sendByte(8'h06, a); sendByte(8'hAA, a); sendByte(8'h81, a);
    sendByte(8'h00, a); sendByte(8'hEE, a);
    chk("R9 unmapped write acknowledged", {7'b0, a}, 8'h01);
    i2cStop;
    chk("R2 sequential write idx6", outCfg, 8'hAA);
    chk("R2 sequential write idx7", oscCfg, 8'h81);
    chk("R6 00h to commit does nothing", 8'(loopCnt - l0 + phaseCnt - p0), 8'h00);
    rdReg(8'h09, rb); chk("R9 unmapped idx9 reads 00h", rb, 8'h00);
    rdReg(8'h20, rb); chk("R9 unmapped idx20h reads 00h", rb, 8'h00);
  endtask

  task automatic testNack;
    logic a;
    i2cStart; sendByte(devAddr(1'b0), a); sendByte(8'h03, a);
    i2cStart; sendByte(devAddr(1'b1), a);
    recvByte(1'b0, rb); chk("R2 read idx3 before nack", rb, 8'h07);
    recvByte(1'b1, rb); chk("R2 read idx4 with nack", rb, 8'h01);
    oeWatch = 1'b1;
    for (int i = 0; i < 9; i++) begin
      waitQ(2); sclHost = 1'b1;
      waitQ(2); sclHost = 1'b0;
    end
    oeWatch = 1'b0;
    chk("R10 SDA released after nack", 8'(oeHits), 8'h00);
    i2cStop;
  endtask

  task automatic testRevision;
    wrReg(8'h05, 8'h81);
    rdReg(8'h05, rb); chk("R8 bits read as written", rb, 8'h81);
    wrReg(8'h05, 8'hFD);
    rdReg(8'h05, rb); chk("R8 code after all-ones write", rb, 8'hB5);
    wrReg(8'h05, 8'h02);
    rdReg(8'h05, rb); chk("R8 code persists", rb, 8'hB6);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R2 act=hung exp=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (5) @(negedge clk);
    testReset;
    testAddress;
    testMsbFirst;
    testShadow;
    testPhaseCommit;
    testIdent;
    testUnmapped;
    testNack;
    testRevision;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule